// File: doc/BRIEF.md
# Auto-Retransmit Packet Controller

This block sequences the transmit side of a packet radio link. A transmission starts when the chip-enable pin rises while a payload is queued and then stays high for a set number of cycles. The controller pulses a start strobe toward the modulator and lets the transmission run for a fixed number of cycles. When auto-acknowledge is off, it reports the packet as sent at once. When auto-acknowledge is on, it opens a listening window and waits for an acknowledge strobe.

If the window closes with no acknowledge, the controller waits for a programmable back-off and sends the same payload again. It does this until the programmed retry limit is used up. A packet that is never acknowledged raises a max-retry flag instead of the done flag. It also bumps a saturating lost-packet counter, and a write to the channel register clears that counter. After an exhausted packet the payload stays at the head of the queue, and no new transmission starts until software clears the max-retry flag.

Top module: `arq_tx_seq`

## Requirements
- R1: A transmission starts only when chip-enable is sampled high for CE_HOLD consecutive clock edges, beginning at its rising edge, and `pl_avail` is high at the last of those edges. `tx_start` then pulses for one cycle, in the cycle after that edge. A shorter pulse, or no queued payload, starts nothing.
- R2: With `auto_ack_en` low, each start gives exactly one transmission. `done_flag` sets and `pl_pop` pulses TX_CYC cycles after the `tx_start` pulse, and `retry_cnt` reads 0.
- R3: With `auto_ack_en` high, `done_flag` sets and `pl_pop` pulses only in the cycle after an acknowledge strobe is sampled inside the window. After the k-th transmission is acknowledged, `retry_cnt` reads k-1.
- R4: With `auto_ack_en` high and no acknowledge, exactly `retry_limit`+1 transmissions occur. Then `maxrt_flag` sets TX_CYC+ACK_WIN cycles after the last `tx_start`. `done_flag` stays clear, no pop occurs, and `retry_cnt` equals `retry_limit`.
- R5: Consecutive `tx_start` pulses of one packet are exactly TX_CYC + ACK_WIN + (`retry_delay`+1)*DLY_UNIT cycles apart.
- R6: `lost_cnt` increments by one for each exhausted packet and saturates at its all-ones value (15 by default). It never steps by more than one.
- R7: A `chan_wr` pulse makes `lost_cnt` read 0 in the next cycle, even if an increment falls in the same cycle.
- R8: An acknowledge strobe outside the listening window is ignored. This includes one given while the packet is still being transmitted.
- R9: While `maxrt_flag` is set, no transmission starts. Once the flag is cleared, the next start resets `retry_cnt` to 0 for the new payload.
- R10: `clr_done` and `clr_maxrt` clear their flags in the next cycle. Reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pl_avail | input | 1 | A payload is queued |
| ce_pin | input | 1 | Chip-enable pin |
| ack_in | input | 1 | Acknowledge-received strobe |
| auto_ack_en | input | 1 | Enables acknowledge waiting and retries |
| retry_limit | input | RTR_W | Maximum number of retransmissions |
| retry_delay | input | DLY_W | Back-off length in units of DLY_UNIT cycles, minus one |
| chan_wr | input | 1 | Channel register write strobe, clears the lost counter |
| clr_done | input | 1 | Clears done_flag |
| clr_maxrt | input | 1 | Clears maxrt_flag |
| tx_start | output | 1 | One-cycle strobe that starts a transmission |
| pl_pop | output | 1 | One-cycle strobe that removes the head payload |
| done_flag | output | 1 | Packet delivered |
| maxrt_flag | output | 1 | Retry limit exhausted |
| lost_cnt | output | LOST_W | Saturating lost-packet count |
| retry_cnt | output | RTR_W | Retransmissions of the current packet |

## Verification
Nearly every fault in the state register or the shared cycle counter shows at the ports within a single packet. A counter off by one moves the next `tx_start` away from the expected spacing. A wrong retry comparison changes the number of transmissions before `done_flag` or `maxrt_flag` appears. A state that fails to return to idle suppresses the next start, and this shows as a missing `tx_start` at the cycle where R1 places it. Faults in the lost counter take longer to show, because they need a run of exhausted packets up to saturation and then a channel write.

// File: rtl/arq_tx_seq.sv
module arq_tx_seq #(
  parameter int CE_HOLD  = 4,
  parameter int TX_CYC   = 3,
  parameter int ACK_WIN  = 8,
  parameter int DLY_UNIT = 2,
  parameter int RTR_W    = 4,
  parameter int DLY_W    = 4,
  parameter int LOST_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pl_avail,
  input  logic              ce_pin,
  input  logic              ack_in,
  input  logic              auto_ack_en,
  input  logic [RTR_W-1:0]  retry_limit,
  input  logic [DLY_W-1:0]  retry_delay,
  input  logic              chan_wr,
  input  logic              clr_done,
  input  logic              clr_maxrt,
  output logic              tx_start,
  output logic              pl_pop,
  output logic              done_flag,
  output logic              maxrt_flag,
  output logic [LOST_W-1:0] lost_cnt,
  output logic [RTR_W-1:0]  retry_cnt
);

  localparam int DLY_MAX = (2 ** DLY_W) * DLY_UNIT;
  localparam int M1      = (CE_HOLD > TX_CYC) ? CE_HOLD : TX_CYC;
  localparam int M2      = (M1 > ACK_WIN) ? M1 : ACK_WIN;
  localparam int CNT_MAX = (M2 > DLY_MAX) ? M2 : DLY_MAX;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] ARM_LAST = CNT_W'(CE_HOLD - 2);
  localparam logic [CNT_W-1:0] TX_LAST  = CNT_W'(TX_CYC - 1);
  localparam logic [CNT_W-1:0] WIN_LAST = CNT_W'(ACK_WIN - 1);

  typedef enum logic [2:0] {S_IDLE, S_ARM, S_TX, S_WAIT, S_GAP} state_t;

  state_t           state;
  logic [CNT_W-1:0] cnt;
  logic             ce_q;
  logic [CNT_W-1:0] gap_last;

  assign gap_last = CNT_W'((int'(retry_delay) + 1) * DLY_UNIT - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cnt        <= '0;
      ce_q       <= 1'b0;
      tx_start   <= 1'b0;
      pl_pop     <= 1'b0;
      done_flag  <= 1'b0;
      maxrt_flag <= 1'b0;
      lost_cnt   <= '0;
      retry_cnt  <= '0;
    end else begin
      ce_q     <= ce_pin;
      tx_start <= 1'b0;
      pl_pop   <= 1'b0;
      if (clr_done)  done_flag  <= 1'b0;
      if (clr_maxrt) maxrt_flag <= 1'b0;

      case (state)
        S_IDLE: begin
          if (ce_pin && !ce_q && !maxrt_flag) begin
            state <= S_ARM;
            cnt   <= '0;
          end
        end
        S_ARM: begin
          if (!ce_pin) begin
            state <= S_IDLE;
          end else if (cnt == ARM_LAST) begin
            cnt <= '0;
            if (pl_avail) begin
              state     <= S_TX;
              tx_start  <= 1'b1;
              retry_cnt <= '0;
            end else begin
              state <= S_IDLE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_TX: begin
          if (cnt == TX_LAST) begin
            cnt <= '0;
            if (auto_ack_en) begin
              state <= S_WAIT;
            end else begin
              state     <= S_IDLE;
              done_flag <= 1'b1;
              pl_pop    <= 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_WAIT: begin
          if (ack_in) begin
            state     <= S_IDLE;
            cnt       <= '0;
            done_flag <= 1'b1;
            pl_pop    <= 1'b1;
          end else if (cnt == WIN_LAST) begin
            cnt <= '0;
            if (retry_cnt >= retry_limit) begin
              state      <= S_IDLE;
              maxrt_flag <= 1'b1;
              if (lost_cnt != '1) lost_cnt <= lost_cnt + 1'b1;
            end else begin
              state     <= S_GAP;
              retry_cnt <= retry_cnt + 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_GAP: begin
          if (cnt == gap_last) begin
            cnt      <= '0;
            state    <= S_TX;
            tx_start <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase

      if (chan_wr) lost_cnt <= '0;
    end
  end

endmodule

// File: rtl/arq_tx_seq_chk.sv
module arq_tx_seq_chk #(
  parameter int LOST_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chan_wr,
  input logic              tx_start,
  input logic              pl_pop,
  input logic              done_flag,
  input logic              maxrt_flag,
  input logic [LOST_W-1:0] lost_cnt
);

  AST_LOST_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (lost_cnt == '1 && !chan_wr) |=> lost_cnt == '1); // R6

  AST_LOST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_wr |=> (lost_cnt == $past(lost_cnt) || lost_cnt == LOST_W'($past(lost_cnt) + 1'b1))); // R6

  AST_LOST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    chan_wr |=> lost_cnt == '0); // R7

  AST_POP_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    pl_pop |-> done_flag); // R3

  AST_NO_START_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> !maxrt_flag); // R9

  AST_MAXRT_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(maxrt_flag) |-> !pl_pop); // R4

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !($rose(done_flag) && $rose(maxrt_flag))); // R4

endmodule

bind arq_tx_seq arq_tx_seq_chk #(.LOST_W(LOST_W)) u_arq_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .chan_wr    (chan_wr),
  .tx_start   (tx_start),
  .pl_pop     (pl_pop),
  .done_flag  (done_flag),
  .maxrt_flag (maxrt_flag),
  .lost_cnt   (lost_cnt)
);

// File: tb/test_arq_tx_seq.sv
`timescale 1ns/1ps
module test_arq_tx_seq;
  localparam int CEH = 4, TXC = 3, AW = 8, DU = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, pl_avail, ce_pin, ack_in, auto_ack_en, chan_wr, clr_done, clr_maxrt;
  logic [3:0] retry_limit, retry_delay;
  logic tx_start, pl_pop, done_flag, maxrt_flag;
  logic [3:0] lost_cnt, retry_cnt;

  arq_tx_seq #(.CE_HOLD(CEH), .TX_CYC(TXC), .ACK_WIN(AW), .DLY_UNIT(DU)) i_arq_tx_seq (
    .clk(clk), .rst_n(rst_n), .pl_avail(pl_avail), .ce_pin(ce_pin), .ack_in(ack_in),
    .auto_ack_en(auto_ack_en), .retry_limit(retry_limit), .retry_delay(retry_delay),
    .chan_wr(chan_wr), .clr_done(clr_done), .clr_maxrt(clr_maxrt),
    .tx_start(tx_start), .pl_pop(pl_pop), .done_flag(done_flag), .maxrt_flag(maxrt_flag),
    .lost_cnt(lost_cnt), .retry_cnt(retry_cnt));

  int n_run = 0, n_fail = 0, lost_exp = 0;

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_flags();
    @(negedge clk); clr_done = 1; clr_maxrt = 1;
    @(negedge clk); clr_done = 0; clr_maxrt = 0;
    chk("R10 done cleared", done_flag, 0);
    chk("R10 maxrt cleared", maxrt_flag, 0);
  endtask

  // CE pulse of 'hold' cycles; expects no transmission
  task automatic no_start(string tag, int hold, bit avail);
    int seen = 0;
    pl_avail = avail;
    @(negedge clk); ce_pin = 1;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (c + 1 >= hold) ce_pin = 0;
      if (tx_start || pl_pop) seen++;
    end
    chk(tag, seen, 0);
  endtask

  task automatic pkt(int lim, int dly, bit aa, int ack_at, bit early);
    int ntx = 0, npop = 0, last = -1, first = -1, ack_due = -1, tend = -1;
    int gap_exp = TXC + AW + (dly + 1) * DU;
    bit acked = aa && ack_at > 0;
    retry_limit = 4'(lim); retry_delay = 4'(dly); auto_ack_en = aa; pl_avail = 1;
    @(negedge clk); ce_pin = 1;
    for (int c = 0; c < 3000 && tend < 0; c++) begin
      @(negedge clk);
      ack_in = 0;
      ce_pin = (c + 1 < CEH + 2);
      if (tx_start) begin
        ntx++;
        if (first < 0) first = c;
        else chk("R5 retransmit spacing", c - last, gap_exp);
        last = c;
        if (early) ack_in = 1;
        if (ntx == ack_at) ack_due = c + TXC + 2;
      end
      if (c == ack_due) ack_in = 1;
      if (pl_pop) npop++;
      if (done_flag || maxrt_flag) tend = c;
    end
    ce_pin = 0; ack_in = 0;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      if (pl_pop) npop++;
      if (tx_start) ntx++;
    end
    chk("R1 start latency", first, CEH - 1);
    if (!aa) begin
      chk("R2 single transmission", ntx, 1);
      chk("R2 done time", tend - first, TXC);
      chk("R2 done", done_flag, 1);
      chk("R2 pop", npop, 1);
      chk("R2 retry_cnt", retry_cnt, 0);
    end else if (acked && !early) begin
      chk("R3 transmissions", ntx, ack_at);
      chk("R3 done time", tend, ack_due + 1);
      chk("R3 done", done_flag, 1);
      chk("R3 no maxrt", maxrt_flag, 0);
      chk("R3 pop", npop, 1);
      chk("R3 retry_cnt", retry_cnt, ack_at - 1);
    end else begin
      if (lost_exp < 15) lost_exp++;
      chk(early ? "R8 early ack ignored" : "R4 transmissions", ntx, lim + 1);
      chk("R4 maxrt time", tend - last, TXC + AW);
      chk("R4 maxrt", maxrt_flag, 1);
      chk("R4 no done", done_flag, 0);
      chk("R4 no pop", npop, 0);
      chk("R4 retry_cnt", retry_cnt, lim);
      chk("R6 lost_cnt", lost_cnt, lost_exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; pl_avail = 0; ce_pin = 0; ack_in = 0; auto_ack_en = 0; chan_wr = 0;
    clr_done = 0; clr_maxrt = 0; retry_limit = 4'd3; retry_delay = 4'd0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 reset outputs", {tx_start, pl_pop, done_flag, maxrt_flag}, 0);
    chk("R10 reset lost_cnt", lost_cnt, 0);
    chk("R10 reset retry_cnt", retry_cnt, 0);

    no_start("R1 no payload", CEH + 2, 0);
    no_start("R1 short CE pulse", CEH - 1, 1);

    for (int l = 0; l < 4; l++) begin
      pkt(l, 1, 0, 0, 0);
      clear_flags();
    end

    for (int l = 0; l < 4; l++)
      for (int d = 0; d < 3; d++)
        for (int a = 0; a <= l + 1; a++) begin
          pkt(l, d, 1, a, 0);
          clear_flags();
        end

    pkt(1, 0, 1, 0, 1);
    clear_flags();

    pkt(2, 1, 1, 0, 0);
    no_start("R9 stalled while maxrt", CEH + 2, 1);
    chk("R9 maxrt held", maxrt_flag, 1);
    clear_flags();
    pkt(3, 0, 1, 1, 0);
    chk("R9 retry_cnt reset on new payload", retry_cnt, 0);
    clear_flags();

    for (int i = 0; i < 3; i++) begin
      pkt(0, 0, 1, 0, 0);
      clear_flags();
    end
    chk("R6 saturated", lost_cnt, 15);

    @(negedge clk); chan_wr = 1;
    @(negedge clk); chan_wr = 0;
    lost_exp = 0;
    chk("R7 channel write clears", lost_cnt, 0);
    pkt(0, 0, 1, 0, 0);
    clear_flags();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule